// File: doc/BRIEF.md
# Tagged Write FIFO with Packed Status Word

This block is a single-channel FIFO that sits between a bus agent and a stream consumer. Each stored entry is a 32-bit data word with a 4-bit tag beside it, and the tag leaves the FIFO together with its word. The bus side can fetch a packed 32-bit status word at any time. It can also push data, one word or a fixed four-word burst per request. The stream side pulls data in the same two ways. It sees a discrete occupancy count and a channel-valid line that is always high.

Both data sides use a request/acknowledge handshake. The burst qualifier is sampled in the cycle a transfer starts. A single-beat request moves exactly one word however long it is held. A burst request is acknowledged on four consecutive cycles and then released. A new transfer on a side begins only after that side's request has been low for at least one cycle. A transfer starts only if the whole of it fits: there must be enough vacancy for a write and enough stored words for a read.

The status word carries three threshold flags in its top bits and the vacancy count in its low bits. It is combinational from the registered fill level, so a status request is acknowledged and answered in the cycle it is raised.

Top module: `tagfifo_top`

## Requirements
- R1: The FIFO holds up to 255 entries, and `occupancy` always equals the number of stored entries. It reads 255 when full.
- R2: While `statReq` is high, `statAck` is high in the same cycle. `statWord` is laid out as follows: bit 31 is full (occupancy 255), bit 30 is almost full (occupancy of 240 or more), bit 29 is half full (occupancy of 128 or more), bits 7:0 hold the vacancy (255 minus occupancy), and bits 28:8 are zero.
- R3: A write request with `wrBurst` low when it starts is acknowledged in that same cycle. It stores exactly one word with its tag at the end of that cycle, and the vacancy drops by one. No further acknowledge follows while `wrReq` stays high.
- R4: A write request with `wrBurst` high when it starts is acknowledged on four consecutive cycles while `wrReq` is held, storing one word per cycle. After those four cycles `wrAck` stays low.
- R5: No write is acknowledged while the FIFO is full. A burst write is not acknowledged when the vacancy is below four, although a single write still is.
- R6: A read request with `rdBurst` low when it starts is acknowledged for exactly one cycle. The head word and its tag appear on `rdData`/`rdTag` in that cycle, and nothing further is delivered while `rdReq` stays high.
- R7: A read request with `rdBurst` high when it starts is acknowledged on four consecutive cycles and delivers four words, one per acknowledged cycle.
- R8: No read is acknowledged while the FIFO is empty. A burst read is not acknowledged when fewer than four words are stored.
- R9: Words leave in the order they were written, and each word leaves with the tag it was written with. This order holds across pointer wrap-around.
- R10: `chanValid` is always high. A write and a read acknowledged in the same cycle leave `occupancy` unchanged.
- R11: After reset, `occupancy` is 0 and the status word reads 0x000000FF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| statReq | input | 1 | Status read request |
| statAck | output | 1 | Status acknowledge, same cycle |
| statWord | output | 32 | Packed flags and vacancy |
| wrReq | input | 1 | Write request |
| wrBurst | input | 1 | Write burst qualifier, sampled at start |
| wrData | input | 32 | Write data word |
| wrTag | input | 4 | Write tag |
| wrAck | output | 1 | Write acknowledge; word stored at end of cycle |
| rdReq | input | 1 | Read request |
| rdBurst | input | 1 | Read burst qualifier, sampled at start |
| rdAck | output | 1 | Read acknowledge; data valid in this cycle |
| rdData | output | 32 | Head data word |
| rdTag | output | 4 | Tag of head word |
| chanValid | output | 1 | Channel valid, constant high |
| occupancy | output | 8 | Number of stored entries |

## Verification
The bench goes after four kinds of corner case. The first is a single-beat request held for several cycles; a sequencer that re-arms on a level instead of a fresh start would hand out repeated acknowledges and move extra words. The second is the edge of capacity: a burst offered with three vacancies or three stored words, and any write at 255. A design that checks only for "not full" or "not empty" would overrun or underrun storage there, and the fill count would wrap. The third is the threshold flags at 128, 240 and 255 and the vacancy field through a complete fill and drain; an off-by-one compare would show up as a wrong status word. The fourth is a simultaneous read and write, together with more than 255 words pushed through the FIFO. A count that mishandles the coincident case would drift, and a pointer that wraps at the wrong entry would return words or tags out of order.

// File: rtl/tagfifo_pkg.sv
package tagfifo_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;
endpackage

// File: rtl/tagfifo_hs.sv
// Request/acknowledge sequencer for one side: single beat or fixed burst.
module tagfifo_hs #(
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic req,
  input  logic burst,
  input  logic roomOne,
  input  logic roomBurst,
  output logic ack
);
  localparam int BW = $clog2(BURST_LEN + 1);

  typedef enum logic [1:0] {IDLE, BURSTING, HOLD} hsState_t;

  hsState_t       state;
  logic [BW-1:0]  beatsLeft;
  logic           start;

  always_comb begin
    start = (state == IDLE) && req && (burst ? roomBurst : roomOne);
    ack   = start || ((state == BURSTING) && req);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= IDLE;
      beatsLeft <= '0;
    end else begin
      case (state)
        IDLE: begin
          if (start) begin
            if (burst) begin
              state     <= BURSTING;
              beatsLeft <= BW'(BURST_LEN - 1);
            end else begin
              state <= HOLD;
            end
          end
        end
        BURSTING: begin
          if (req) begin
            beatsLeft <= beatsLeft - 1'b1;
            if (beatsLeft == BW'(1)) state <= HOLD;
          end
        end
        HOLD: begin
          if (!req) state <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tagfifo_ctrl.sv
// Control: two handshake sequencers, fill count and threshold flags.
module tagfifo_ctrl
  import tagfifo_pkg::*;
#(
  parameter int DEPTH     = 255,
  parameter int BURST_LEN = 4,
  parameter int HALF_TH   = 128,
  parameter int ALMOST_TH = 240,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrReq,
  input  logic              wrBurst,
  input  logic              rdReq,
  input  logic              rdBurst,
  output logic              wrAck,
  output logic              rdAck,
  output fifoStrobe_t       strobe,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  vacancy,
  output logic              full,
  output logic              almostFull,
  output logic              halfFull
);
  logic wrRoomOne, wrRoomBurst, rdRoomOne, rdRoomBurst;

  always_comb begin
    vacancy     = CNT_W'(DEPTH) - count;
    wrRoomOne   = int'(vacancy) >= 1;
    wrRoomBurst = int'(vacancy) >= BURST_LEN;
    rdRoomOne   = int'(count) >= 1;
    rdRoomBurst = int'(count) >= BURST_LEN;
    full        = int'(count) == DEPTH;
    almostFull  = int'(count) >= ALMOST_TH;
    halfFull    = int'(count) >= HALF_TH;
    strobe.push = wrAck;
    strobe.pop  = rdAck;
  end

  tagfifo_hs #(.BURST_LEN(BURST_LEN)) u_wrHs (
    .clk(clk), .rstN(rstN), .req(wrReq), .burst(wrBurst),
    .roomOne(wrRoomOne), .roomBurst(wrRoomBurst), .ack(wrAck)
  );

  tagfifo_hs #(.BURST_LEN(BURST_LEN)) u_rdHs (
    .clk(clk), .rstN(rstN), .req(rdReq), .burst(rdBurst),
    .roomOne(rdRoomOne), .roomBurst(rdRoomBurst), .ack(rdAck)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tagfifo_dp.sv
// Datapath: entry storage of data plus tag, circular pointers.
module tagfifo_dp
  import tagfifo_pkg::*;
#(
  parameter int DEPTH  = 255,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [TAG_W-1:0]  wrTag,
  output logic [DATA_W-1:0] rdData,
  output logic [TAG_W-1:0]  rdTag
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int ENT_W = DATA_W + TAG_W;

  logic [ENT_W-1:0] mem [0:DEPTH-1];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= {wrTag, wrData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  always_comb begin
    {rdTag, rdData} = mem[rdPtr];
  end
endmodule

// File: rtl/tagfifo_top.sv
// Thin top: status word packing and wiring.
module tagfifo_top
  import tagfifo_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int TAG_W     = 4,
  parameter int DEPTH     = 255,
  parameter int BURST_LEN = 4,
  parameter int HALF_TH   = 128,
  parameter int ALMOST_TH = 240,
  parameter int STAT_W    = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         statReq,
  output logic                         statAck,
  output logic [STAT_W-1:0]            statWord,
  input  logic                         wrReq,
  input  logic                         wrBurst,
  input  logic [DATA_W-1:0]            wrData,
  input  logic [TAG_W-1:0]             wrTag,
  output logic                         wrAck,
  input  logic                         rdReq,
  input  logic                         rdBurst,
  output logic                         rdAck,
  output logic [DATA_W-1:0]            rdData,
  output logic [TAG_W-1:0]             rdTag,
  output logic                         chanValid,
  output logic [$clog2(DEPTH+1)-1:0]   occupancy
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PAD_W = STAT_W - 3 - CNT_W;

  fifoStrobe_t      strobe;
  logic [CNT_W-1:0] vacancy;
  logic             full, almostFull, halfFull;

  tagfifo_ctrl #(
    .DEPTH(DEPTH), .BURST_LEN(BURST_LEN), .HALF_TH(HALF_TH),
    .ALMOST_TH(ALMOST_TH), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrReq(wrReq), .wrBurst(wrBurst), .rdReq(rdReq), .rdBurst(rdBurst),
    .wrAck(wrAck), .rdAck(rdAck), .strobe(strobe),
    .count(occupancy), .vacancy(vacancy),
    .full(full), .almostFull(almostFull), .halfFull(halfFull)
  );

  tagfifo_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(wrData), .wrTag(wrTag), .rdData(rdData), .rdTag(rdTag)
  );

  always_comb begin
    statAck   = statReq;
    statWord  = {full, almostFull, halfFull, {PAD_W{1'b0}}, vacancy};
    chanValid = 1'b1;
  end
endmodule

// File: rtl/tagfifo_chk.sv
// Property checker attached to the top module.
module tagfifo_chk #(
  parameter int DEPTH     = 255,
  parameter int HALF_TH   = 128,
  parameter int STAT_W    = 32,
  parameter int CNT_W     = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              statReq,
  input logic              statAck,
  input logic [STAT_W-1:0] statWord,
  input logic              wrReq,
  input logic              wrAck,
  input logic              rdReq,
  input logic              rdBurst,
  input logic              rdAck,
  input logic              chanValid,
  input logic [CNT_W-1:0]  occupancy
);
  p_stat_vacancy_r2: assert property (@(posedge clk) disable iff (!rstN)
    statReq |-> statAck && (int'(statWord[CNT_W-1:0]) + int'(occupancy) == DEPTH));

  p_half_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    statReq |-> statWord[STAT_W-3] == (int'(occupancy) >= HALF_TH));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (int'(occupancy) == DEPTH) |-> !wrAck);

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (occupancy == '0) |-> !rdAck);

  p_count_up_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrAck && !rdAck) |=> occupancy == $past(occupancy) + 1'b1);

  p_count_down_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdAck && !wrAck) |=> occupancy == $past(occupancy) - 1'b1);

  p_count_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrAck == rdAck) |=> $stable(occupancy));

  p_wr_ack_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrAck |-> wrReq);

  p_rd_ack_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdAck |-> rdReq);

  p_single_read_once_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rdAck) && !rdBurst) |=> !rdAck);

  p_chan_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    chanValid);
endmodule

bind tagfifo_top tagfifo_chk #(
  .DEPTH(DEPTH), .HALF_TH(HALF_TH), .STAT_W(STAT_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .statReq(statReq), .statAck(statAck),
  .statWord(statWord), .wrReq(wrReq), .wrAck(wrAck), .rdReq(rdReq),
  .rdBurst(rdBurst), .rdAck(rdAck), .chanValid(chanValid),
  .occupancy(occupancy)
);

// File: tb/tb_tagfifo_top.sv
module tb_tagfifo_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 255;
  localparam int BLEN  = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        statReq = 1'b0, statAck;
  logic [31:0] statWord;
  logic        wrReq = 1'b0, wrBurst = 1'b0, wrAck;
  logic [31:0] wrData = '0;
  logic [3:0]  wrTag = '0;
  logic        rdReq = 1'b0, rdBurst = 1'b0, rdAck;
  logic [31:0] rdData;
  logic [3:0]  rdTag;
  logic        chanValid;
  logic [7:0]  occupancy;

  tagfifo_top dut (
    .clk(clk), .rstN(rstN), .statReq(statReq), .statAck(statAck),
    .statWord(statWord), .wrReq(wrReq), .wrBurst(wrBurst), .wrData(wrData),
    .wrTag(wrTag), .wrAck(wrAck), .rdReq(rdReq), .rdBurst(rdBurst),
    .rdAck(rdAck), .rdData(rdData), .rdTag(rdTag), .chanValid(chanValid),
    .occupancy(occupancy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model
  logic [31:0] mData [0:511];
  logic [3:0]  mTag  [0:511];
  int mHead = 0, mTail = 0, mCount = 0, seq = 0;

  // table: {op[1:0], burst, expOcc[7:0]}; op 0=status 1=write 2=read
  localparam int NVEC = 14;
  localparam logic [10:0] VEC [NVEC] = '{
    {2'd2, 1'b0, 8'd0}, {2'd2, 1'b1, 8'd0}, {2'd1, 1'b0, 8'd1},
    {2'd1, 1'b1, 8'd5}, {2'd0, 1'b0, 8'd5}, {2'd2, 1'b1, 8'd1},
    {2'd2, 1'b1, 8'd1}, {2'd1, 1'b0, 8'd2}, {2'd1, 1'b1, 8'd6},
    {2'd2, 1'b0, 8'd5}, {2'd0, 1'b0, 8'd5}, {2'd2, 1'b0, 8'd4},
    {2'd2, 1'b1, 8'd0}, {2'd0, 1'b0, 8'd0}
  };

  function automatic logic [31:0] expStat(input int cnt);
    return {cnt == DEPTH, cnt >= 240, cnt >= 128, 21'b0, 8'(DEPTH - cnt)};
  endfunction

  function automatic logic [31:0] genData(input int s);
    return 32'h5EED_0000 + 32'(s * 7);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic statusCheck(input string req);
    @(negedge clk);
    statReq = 1'b1;
    #1;
    chk("R2", "statAck", 32'(statAck), 32'd1);
    chk(req, "statWord", statWord, expStat(mCount));
    chk("R1", "occupancy", 32'(occupancy), 32'(mCount));
    @(negedge clk);
    statReq = 1'b0;
  endtask

  // one transfer, request held 7 cycles; counts acks against expectation
  task automatic xfer(input bit isWr, input bit burst);
    int room, expN, got;
    bit patOk;
    string tag;
    room = isWr ? (DEPTH - mCount) : mCount;
    expN = burst ? ((room >= BLEN) ? BLEN : 0) : ((room >= 1) ? 1 : 0);
    if (expN == 0) tag = isWr ? "R5" : "R8";
    else tag = isWr ? (burst ? "R4" : "R3") : (burst ? "R7" : "R6");
    got = 0;
    patOk = 1;
    @(negedge clk);
    if (isWr) begin wrReq = 1'b1; wrBurst = burst; end
    else begin rdReq = 1'b1; rdBurst = burst; end
    for (int c = 0; c < 7; c++) begin
      if (isWr) begin wrData = genData(seq); wrTag = 4'(seq); end
      #1;
      if ((isWr ? wrAck : rdAck) != (c < expN)) patOk = 0;
      if (isWr ? wrAck : rdAck) begin
        got++;
        if (isWr) begin
          mData[mTail % 512] = genData(seq); mTag[mTail % 512] = 4'(seq);
          mTail++; mCount++; seq++;
        end else begin
          chk("R9", "rdData", rdData, mData[mHead % 512]);
          chk("R9", "rdTag", 32'(rdTag), 32'(mTag[mHead % 512]));
          mHead++; mCount--;
        end
      end
      @(negedge clk);
    end
    wrReq = 1'b0; wrBurst = 1'b0; rdReq = 1'b0; rdBurst = 1'b0;
    chk(tag, "ack count", 32'(got), 32'(expN));
    chk(tag, "ack pattern", 32'(patOk), 32'd1);
    @(negedge clk);
    #1;
    chk("R1", "occupancy after transfer", 32'(occupancy), 32'(mCount));
  endtask

  // simultaneous single write and single read
  task automatic bothSingle();
    @(negedge clk);
    wrReq = 1'b1; rdReq = 1'b1; wrData = genData(seq); wrTag = 4'(seq);
    #1;
    chk("R10", "wrAck both", 32'(wrAck), 32'd1);
    chk("R10", "rdAck both", 32'(rdAck), 32'd1);
    chk("R9", "rdData both", rdData, mData[mHead % 512]);
    mHead++;
    mData[mTail % 512] = genData(seq); mTag[mTail % 512] = 4'(seq);
    mTail++; seq++;
    @(negedge clk);
    #1;
    chk("R3", "no second wrAck", 32'(wrAck), 32'd0);
    chk("R6", "no second rdAck", 32'(rdAck), 32'd0);
    chk("R10", "occupancy unchanged", 32'(occupancy), 32'(mCount));
    @(negedge clk);
    wrReq = 1'b0; rdReq = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    #1;
    chk("R11", "occupancy at reset", 32'(occupancy), 32'd0);
    chk("R11", "status at reset", statWord, 32'h0000_00FF);
    chk("R10", "chanValid", 32'(chanValid), 32'd1);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][10:9])
        2'd0: statusCheck("R2");
        2'd1: xfer(1'b1, VEC[i][8]);
        default: xfer(1'b0, VEC[i][8]);
      endcase
      chk("R1", "table occupancy", 32'(occupancy), 32'(VEC[i][7:0]));
    end

    // fill by bursts, watching flags at each level
    while (mCount + BLEN <= DEPTH) begin
      xfer(1'b1, 1'b1);
      statusCheck("R2");
    end
    xfer(1'b1, 1'b1);                 // vacancy 3: burst refused R5
    for (int k = 0; k < 3; k++) xfer(1'b1, 1'b0);
    statusCheck("R2");
    chk("R2", "full status word", statWord, 32'hE000_0000);
    chk("R1", "full occupancy", 32'(occupancy), 32'd255);
    xfer(1'b1, 1'b0);                 // full: single refused R5
    xfer(1'b1, 1'b1);                 // full: burst refused R5
    xfer(1'b0, 1'b0);
    bothSingle();
    // drain with wrap-around order check
    while (mCount >= BLEN) begin
      xfer(1'b0, 1'b1);
      statusCheck("R2");
    end
    xfer(1'b0, 1'b1);                 // fewer than four stored: refused R8
    while (mCount > 0) xfer(1'b0, 1'b0);
    xfer(1'b0, 1'b0);                 // empty R8
    statusCheck("R11");

    // reset mid-stream R11
    xfer(1'b1, 1'b1);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    mHead = 0; mTail = 0; mCount = 0;
    #1;
    chk("R11", "occupancy after reset", 32'(occupancy), 32'd0);
    chk("R11", "status after reset", statWord, 32'h0000_00FF);
    xfer(1'b1, 1'b0);
    xfer(1'b0, 1'b0);

    done = 1;
    summary();
    $finish;
  end
endmodule